// File: doc/BRIEF.md
# Segment Display RAM Write and Command Controller

This block sits behind a serial byte receiver in a segment LCD driver. Each received byte comes with a flag that marks it as a command or as display data. Command bytes load the address pointer, pick the display mode, write a single nibble, or return the block to its idle state. Display-data bytes store two nibbles at once.

The block holds an 18-entry by 4-bit display memory. Every entry is exposed at the same time on one flat output vector, so a downstream waveform generator can scan the whole memory without any read handshake. The current address and the display mode are also registered outputs.

Every accepted byte takes effect at the rising clock edge that samples `in_valid` high. The result is visible on the outputs from that edge onward.

Top module: `segram_ctrl`

## Requirements
- R1: After the synchronous active-high `rst`, `disp_mode` is 0 (blank), `cur_addr` is 0 and every memory entry reads 0.
- R2: A command byte whose top three bits are 000 loads bits 4..0 into `cur_addr`.
- R3: A command byte whose top three bits are 001 sets `disp_mode` to 1 (all segments lit) and leaves the memory unchanged.
- R4: A command byte whose top three bits are 010 sets `disp_mode` to 0 (all segments dark) and leaves the memory unchanged.
- R5: A command byte whose top three bits are 011 sets `disp_mode` to 2 (driven from memory).
- R6: A command byte of the form 100xDDDD writes DDDD to the entry at `cur_addr`, then advances the address by 1.
- R7: A display-data byte writes bits 7..4 to the entry at `cur_addr` and bits 3..0 to the entry at the next address, then advances the address by 2.
- R8: Advancing from address 17 gives 0. A data byte at address 17 writes entries 17 and 0 and leaves the address at 1.
- R9: A write aimed at addresses 18..31 changes no entry. The address still advances, counting modulo 32 except that 17 steps to 0.
- R10: A command byte of the form 11x0xxxx sets `disp_mode` to 0 and `cur_addr` to 0, and keeps the memory contents.
- R11: The command encodings 101xxxxx and 11x1xxxx change neither the memory, the address nor the mode.
- R12: While `in_valid` is low, no output changes.
- R13: Entry k sits at `ram_flat[4k+3:4k]`. Its bit 3 drives the first common line and its bit 0 drives the fourth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe, one cycle per byte |
| in_byte | input | 8 | Received byte, MSB first as sent |
| in_is_cmd | input | 1 | 1 = command byte, 0 = display data |
| ram_flat | output | 72 | All memory entries, entry k at bits 4k+3..4k |
| cur_addr | output | 5 | Current address counter |
| disp_mode | output | 2 | 0 = blank, 1 = all lit, 2 = from memory |

## Verification
A display-data byte carries two nibble writes that land in the same cycle. The case that matters is when the second write wraps from entry 17 to entry 0, or when the first write falls out of range at address 31 while the second still lands on entry 0. The bench sets the address to 17 and to 31 and then sends a data byte. It judges the result by comparing both target entries and the final address against a reference model after that one edge.

Back-to-back bytes also make an address load and the following write fall on adjacent edges. This checks that the fresh pointer is used at once.

// File: rtl/segram_pkg.sv
package segram_pkg;

  typedef enum logic [1:0] {
    MODE_BLANK  = 2'd0,
    MODE_LIT    = 2'd1,
    MODE_MEMORY = 2'd2
  } disp_mode_e;

  typedef struct packed {
    logic ptr_load;
    logic nib_write;
    logic pair_write;
    logic set_lit;
    logic set_blank;
    logic set_memory;
    logic soft_clear;
  } op_s;

endpackage

// File: rtl/segram_decode.sv
module segram_decode
  import segram_pkg::*;
(
  input  logic       valid,
  input  logic [7:0] byte_in,
  input  logic       is_cmd,
  output op_s        op
);

  always_comb begin
    op = '0;
    if (valid) begin
      if (!is_cmd) begin
        op.pair_write = 1'b1;
      end else begin
        case (byte_in[7:5])
          3'b000:  op.ptr_load   = 1'b1;
          3'b001:  op.set_lit    = 1'b1;
          3'b010:  op.set_blank  = 1'b1;
          3'b011:  op.set_memory = 1'b1;
          3'b100:  op.nib_write  = 1'b1;
          3'b110,
          3'b111:  op.soft_clear = !byte_in[4];
          default: op = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/segram_addr.sv
module segram_addr
  import segram_pkg::*;
#(
  parameter int AW       = 5,
  parameter int NUM_ADDR = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  op_s           op,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] ptr_next
);

  localparam logic [AW-1:0] LAST = AW'(NUM_ADDR - 1);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a);
    return (a == LAST) ? '0 : a + 1'b1;
  endfunction

  assign ptr_next = step(ptr);

  always_ff @(posedge clk) begin
    if (rst || op.soft_clear) begin
      ptr <= '0;
    end else if (op.ptr_load) begin
      ptr <= load_val;
    end else if (op.nib_write) begin
      ptr <= ptr_next;
    end else if (op.pair_write) begin
      ptr <= step(ptr_next);
    end
  end

  AST_LOAD_PTR: assert property (@(posedge clk) disable iff (rst)
    op.ptr_load && !op.soft_clear |=> ptr == $past(load_val)); // R2

  AST_WRAP_ONE: assert property (@(posedge clk) disable iff (rst)
    op.nib_write && ptr == LAST |=> ptr == '0); // R8

  AST_WRAP_TWO: assert property (@(posedge clk) disable iff (rst)
    op.pair_write && ptr == LAST |=> ptr == AW'(1)); // R8

endmodule

// File: rtl/segram_store.sv
module segram_store #(
  parameter int NUM_ADDR = 18,
  parameter int AW       = 5,
  parameter int NW       = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we_a,
  input  logic [AW-1:0]          addr_a,
  input  logic [NW-1:0]          din_a,
  input  logic                   we_b,
  input  logic [AW-1:0]          addr_b,
  input  logic [NW-1:0]          din_b,
  output logic [NUM_ADDR*NW-1:0] flat
);

  localparam logic [AW-1:0] LIMIT = AW'(NUM_ADDR);

  logic hit_a_ok, hit_b_ok;
  assign hit_a_ok = we_a && (addr_a < LIMIT);
  assign hit_b_ok = we_b && (addr_b < LIMIT);

  for (genvar k = 0; k < NUM_ADDR; k++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        flat[k*NW +: NW] <= '0;
      end else if (hit_a_ok && addr_a == AW'(k)) begin
        flat[k*NW +: NW] <= din_a;
      end else if (hit_b_ok && addr_b == AW'(k)) begin
        flat[k*NW +: NW] <= din_b;
      end
    end
  end

  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !hit_a_ok && !hit_b_ok |=> $stable(flat)); // R9

  AST_PORTS_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    hit_a_ok && hit_b_ok |-> addr_a != addr_b); // R7

endmodule

// File: rtl/segram_ctrl.sv
module segram_ctrl
  import segram_pkg::*;
#(
  parameter int NUM_ADDR = 18,
  parameter int AW       = 5,
  parameter int NW       = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [7:0]             in_byte,
  input  logic                   in_is_cmd,
  output logic [NUM_ADDR*NW-1:0] ram_flat,
  output logic [AW-1:0]          cur_addr,
  output logic [1:0]             disp_mode
);

  op_s           op;
  logic [AW-1:0] ptr_next;
  logic [NW-1:0] first_nib;
  disp_mode_e    mode_q;

  segram_decode u_decode (
    .valid   (in_valid),
    .byte_in (in_byte),
    .is_cmd  (in_is_cmd),
    .op      (op)
  );

  segram_addr #(.AW(AW), .NUM_ADDR(NUM_ADDR)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .load_val (in_byte[AW-1:0]),
    .ptr      (cur_addr),
    .ptr_next (ptr_next)
  );

  assign first_nib = op.pair_write ? in_byte[7:4] : in_byte[NW-1:0];

  segram_store #(.NUM_ADDR(NUM_ADDR), .AW(AW), .NW(NW)) u_store (
    .clk    (clk),
    .rst    (rst),
    .we_a   (op.pair_write | op.nib_write),
    .addr_a (cur_addr),
    .din_a  (first_nib),
    .we_b   (op.pair_write),
    .addr_b (ptr_next),
    .din_b  (in_byte[NW-1:0]),
    .flat   (ram_flat)
  );

  always_ff @(posedge clk) begin
    if (rst || op.soft_clear || op.set_blank) begin
      mode_q <= MODE_BLANK;
    end else if (op.set_lit) begin
      mode_q <= MODE_LIT;
    end else if (op.set_memory) begin
      mode_q <= MODE_MEMORY;
    end
  end

  assign disp_mode = mode_q;

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_is_cmd && in_byte[7:6] == 2'b11 && !in_byte[4]
    |=> disp_mode == 2'd0 && cur_addr == '0 && $stable(ram_flat)); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(cur_addr) && $stable(disp_mode) && $stable(ram_flat)); // R12

  AST_LIT_KEEPS_RAM: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_is_cmd && in_byte[7:5] == 3'b001
    |=> disp_mode == 2'd1 && $stable(ram_flat)); // R3

  AST_UNLISTED: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_is_cmd && (in_byte[7:5] == 3'b101 || (in_byte[7:6] == 2'b11 && in_byte[4]))
    |=> $stable(cur_addr) && $stable(disp_mode) && $stable(ram_flat)); // R11

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    disp_mode != 2'd3); // R5

endmodule

// File: tb/tb_segram_ctrl.sv
`timescale 1ns/1ps
module tb_segram_ctrl;

  localparam int N = 18;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [7:0]    in_byte;
  logic          in_is_cmd;
  logic [N*4-1:0] ram_flat;
  logic [4:0]    cur_addr;
  logic [1:0]    disp_mode;

  always #4 clk = ~clk;

  segram_ctrl dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_is_cmd(in_is_cmd), .ram_flat(ram_flat), .cur_addr(cur_addr),
    .disp_mode(disp_mode)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] m_ram [N];
  logic [4:0] m_addr;
  logic [1:0] m_mode;

  logic [N*4-1:0] q_ram [$];
  logic [4:0]     q_addr [$];
  logic [1:0]     q_mode [$];
  string          q_tag [$];

  logic vld_q = 1'b0;

  function automatic logic [4:0] minc(input logic [4:0] a);
    return (a == 5'd17) ? 5'd0 : a + 5'd1;
  endfunction

  function automatic logic [N*4-1:0] model_flat();
    logic [N*4-1:0] f;
    for (int k = 0; k < N; k++) f[k*4 +: 4] = m_ram[k];
    return f;
  endfunction

  task automatic check(input string tag, input string what, input logic [N*4-1:0] act, input logic [N*4-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic mwrite(input logic [4:0] a, input logic [3:0] d);
    if (a < 5'd18) m_ram[a] = d;
  endtask

  task automatic send(input logic [7:0] b, input logic cmd, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_is_cmd = cmd;
    if (!cmd) begin
      mwrite(m_addr, b[7:4]);
      mwrite(minc(m_addr), b[3:0]);
      m_addr = minc(minc(m_addr));
    end else begin
      case (b[7:5])
        3'b000: m_addr = b[4:0];
        3'b001: m_mode = 2'd1;
        3'b010: m_mode = 2'd0;
        3'b011: m_mode = 2'd2;
        3'b100: begin mwrite(m_addr, b[3:0]); m_addr = minc(m_addr); end
        3'b110, 3'b111: if (!b[4]) begin m_mode = 2'd0; m_addr = 5'd0; end
        default: ;
      endcase
    end
    q_ram.push_back(model_flat());
    q_addr.push_back(m_addr);
    q_mode.push_back(m_mode);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; in_byte = 8'h00; in_is_cmd = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) vld_q <= in_valid && !rst;

  always @(negedge clk) begin
    if (vld_q && q_tag.size() > 0) begin
      string t;
      t = q_tag.pop_front();
      check(t, "ram", ram_flat, q_ram.pop_front());
      check(t, "addr", {67'b0, cur_addr}, {67'b0, q_addr.pop_front()});
      check(t, "mode", {70'b0, disp_mode}, {70'b0, q_mode.pop_front()});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_byte = 8'h00; in_is_cmd = 1'b0;
    for (int k = 0; k < N; k++) m_ram[k] = 4'h0;
    m_addr = 5'd0; m_mode = 2'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "ram", ram_flat, '0);
    check("R1", "addr", {67'b0, cur_addr}, '0);
    check("R1", "mode", {70'b0, disp_mode}, '0);

    send(8'h05, 1'b1, "R2");
    send(8'hA7, 1'b0, "R7");
    send(8'h83, 1'b1, "R6");
    send(8'h20, 1'b1, "R3");
    send(8'h40, 1'b1, "R4");
    send(8'h60, 1'b1, "R5");
    idle(2);
    send(8'h11, 1'b1, "R2");
    send(8'h5C, 1'b0, "R8");
    send(8'h11, 1'b1, "R2");
    send(8'h89, 1'b1, "R8");
    send(8'h14, 1'b1, "R2");
    send(8'hFF, 1'b0, "R9");
    send(8'h1F, 1'b1, "R2");
    send(8'h3E, 1'b0, "R9");
    send(8'h12, 1'b1, "R2");
    send(8'h86, 1'b1, "R9");
    send(8'hA5, 1'b1, "R11");
    send(8'hD0, 1'b1, "R11");
    send(8'hF3, 1'b1, "R11");
    send(8'h20, 1'b1, "R3");
    send(8'h09, 1'b1, "R2");
    send(8'hC0, 1'b1, "R10");
    send(8'hE7, 1'b1, "R10");
    idle(1);

    // R12: strobe low, bytes on the bus must be ignored
    @(negedge clk);
    in_byte = 8'h8F; in_is_cmd = 1'b1;
    repeat (3) @(negedge clk);
    in_byte = 8'hFF; in_is_cmd = 1'b0;
    repeat (2) @(negedge clk);
    check("R12", "ram", ram_flat, model_flat());
    check("R12", "addr", {67'b0, cur_addr}, {67'b0, m_addr});
    check("R12", "mode", {70'b0, disp_mode}, {70'b0, m_mode});

    // R13: one lit bit at entry 2 bit 3 (first common) lands at ram_flat[11]
    send(8'h02, 1'b1, "R2");
    send(8'h88, 1'b1, "R13");
    send(8'h41, 1'b0, "R7");
    idle(1);
    check("R13", "bit11", {71'b0, ram_flat[11]}, 72'd1);
    check("R13", "bit8", {71'b0, ram_flat[8]}, 72'd0);
    check("R13", "entry3", {68'b0, ram_flat[15:12]}, {68'b0, 4'h4});

    send(8'h60, 1'b1, "R5");
    idle(2);
    finish_run();
  end

endmodule